// File: doc/BRIEF.md
# USB Frame Interval Timer

This block keeps the 1 ms frame rhythm of a USB host controller that follows the open host interface model. A 14-bit down-counter steps once for every full-speed bit-time tick (12 MHz) that arrives while the timer is running. A tick that finds the counter at zero closes the frame. On that tick the counter reloads from a programmable interval and takes over the interval's toggle flag. The 16-bit frame number advances, an end-of-frame pulse is produced, and a start-of-frame pulse follows one cycle later.

At each frame end a small companion unit decides whether the done-queue head pointer is handed back to software. The hand-back needs the write-back delay counter at zero and the writeback-done request clear. When it happens, the head is captured and then cleared, the request is raised, and the delay counter is loaded with 7. Bit 0 of the captured value records that another enabled interrupt was pending. A test strobe can force the delay counter back to zero. Memory write-back and list scheduling belong to neighbouring blocks.

Top module: `usb_frame_timer`

## Requirements
- R1: After synchronous reset the frame number, remaining value, delay counter, done head, captured head, writeback-done request and both pulses are all zero. The interval count resets to 11999 and its toggle flag to 0.
- R2: The remaining count changes only on a cycle with run_en=1 and bit_tick=1. On such a cycle a nonzero count decreases by exactly one. With run_en=0, ticks are ignored.
- R3: A counting tick that finds the count at zero reloads the count from the interval count and the remaining toggle (remaining bit 31) from the interval toggle. The same tick adds one to the frame number.
- R4: eof_pulse is high for the single cycle after the clock edge that ends a frame, and sof_pulse is high in the cycle after that.
- R5: A remaining write applies three separate enables. rem_lo_we loads count bits 7:0 and rem_hi_we loads count bits 13:8, both from rem_cnt_in. rem_tgl_we loads bit 31 from rem_tgl_in. Bits without their enable keep their value, and remaining bits 30:14 always read as zero.
- R6: A remaining write in the same cycle as a counting tick takes precedence. The tick is dropped, with no frame end, no frame-number change and no pulse.
- R7: A done-head write stores bits 31:4, and done_head bits 3:0 always read as zero.
- R8: At a frame end with the delay counter at 0 and wdh_irq low, the done head is captured into done_capt. In the same cycle done_head becomes zero, wdh_irq goes high and the delay counter becomes 7. A done-head write in that cycle is lost. With wdh_irq high, a frame end leaves the done head and the delay counter unchanged.
- R9: Bit 0 of done_capt equals irq_other_pend at the capturing frame end.
- R10: At a frame end the delay counter decreases only when it is neither 0 nor 7. Once at 7 it stays there until dly_zero forces it to 0, and dly_zero wins over any frame-end update.
- R11: wdh_clr clears wdh_irq. A capture in the same cycle wins and leaves it set.
- R12: The frame number wraps from 16'hFFFF to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Timer runs while high |
| bit_tick | input | 1 | One-cycle 12 MHz bit-time tick |
| ivl_wr | input | 1 | Interval write strobe |
| ivl_cnt_in | input | 14 | New interval count |
| ivl_tgl_in | input | 1 | New interval toggle flag |
| rem_lo_we | input | 1 | Load remaining count bits 7:0 |
| rem_hi_we | input | 1 | Load remaining count bits 13:8 |
| rem_tgl_we | input | 1 | Load remaining toggle bit |
| rem_cnt_in | input | 14 | Remaining count write data |
| rem_tgl_in | input | 1 | Remaining toggle write data |
| dh_wr | input | 1 | Done-head write strobe |
| dh_wdata | input | 28 | Done-head bits 31:4 |
| wdh_clr | input | 1 | Clear writeback-done request |
| dly_zero | input | 1 | Test strobe forcing the delay counter to 0 |
| irq_other_pend | input | 1 | Another enabled interrupt is pending |
| frame_num | output | 16 | Frame number |
| remaining | output | 32 | Toggle in bit 31, count in bits 13:0 |
| sof_pulse | output | 1 | Start-of-frame pulse |
| eof_pulse | output | 1 | End-of-frame pulse |
| wdh_irq | output | 1 | Writeback-done interrupt request |
| done_head | output | 32 | Current done-queue head |
| done_capt | output | 32 | Head captured at the last hand-back |
| dly_cnt | output | 3 | Write-back delay counter |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a software write to the remaining register and a tick that would end the frame. The bench drives both on one edge while the count sits at zero. It then expects the written count, no end-of-frame pulse and an unchanged frame number. The second pair is a capture and a clear of the writeback-done request. The bench raises wdh_clr on the very tick that ends an eligible frame and expects the request to stay set with the new head captured.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int FRM_CNT_W     = 14;     // remaining / interval count width
  localparam int FRM_NUM_W     = 16;     // frame number width
  localparam int FRM_DATA_W    = 32;     // register width
  localparam int FRM_TGL_BIT   = 31;     // toggle flag position
  localparam int FRM_DH_LSB    = 4;      // lowest stored done-head bit
  localparam int FRM_DLY_LOAD  = 7;      // delay value after a hand-back
  localparam int FRM_IVL_RESET = 11999;  // 12000 bit times per frame
endpackage

// File: rtl/frm_remaining.sv
module frm_remaining #(
  parameter int CNT_W     = 14,
  parameter int IVL_RESET = 11999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             ivl_wr,
  input  logic [CNT_W-1:0] ivl_cnt_in,
  input  logic             ivl_tgl_in,
  input  logic             rem_lo_we,
  input  logic             rem_hi_we,
  input  logic             rem_tgl_we,
  input  logic [CNT_W-1:0] rem_cnt_in,
  input  logic             rem_tgl_in,
  output logic [CNT_W-1:0] cnt,
  output logic             tgl,
  output logic [CNT_W-1:0] ivl_cnt,
  output logic             wrap
);
  localparam int LO_W = (CNT_W < 8) ? CNT_W : 8;

  logic [CNT_W-1:0] cnt_q, nxt_cnt, ivl_cnt_q;
  logic             tgl_q, nxt_tgl, ivl_tgl_q;
  logic             any_wr;

  assign any_wr = rem_lo_we | rem_hi_we | rem_tgl_we;

  always_comb begin
    nxt_cnt = cnt_q;
    nxt_tgl = tgl_q;
    wrap    = 1'b0;
    if (any_wr) begin
      // a software write takes the cycle; the tick is dropped
      for (int i = 0; i < CNT_W; i++) begin
        if (i < LO_W) begin
          if (rem_lo_we) nxt_cnt[i] = rem_cnt_in[i];
        end else begin
          if (rem_hi_we) nxt_cnt[i] = rem_cnt_in[i];
        end
      end
      if (rem_tgl_we) nxt_tgl = rem_tgl_in;
    end else if (step) begin
      if (cnt_q == '0) begin
        nxt_cnt = ivl_cnt_q;
        nxt_tgl = ivl_tgl_q;
        wrap    = 1'b1;
      end else begin
        nxt_cnt = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      tgl_q     <= 1'b0;
      ivl_cnt_q <= CNT_W'(IVL_RESET);
      ivl_tgl_q <= 1'b0;
    end else begin
      cnt_q <= nxt_cnt;
      tgl_q <= nxt_tgl;
      if (ivl_wr) begin
        ivl_cnt_q <= ivl_cnt_in;
        ivl_tgl_q <= ivl_tgl_in;
      end
    end
  end

  assign cnt     = cnt_q;
  assign tgl     = tgl_q;
  assign ivl_cnt = ivl_cnt_q;
endmodule

// File: rtl/frm_number.sv
module frm_number #(
  parameter int FN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  output logic [FN_W-1:0] num
);
  always_ff @(posedge clk) begin
    if (rst)      num <= '0;
    else if (inc) num <= num + FN_W'(1);
  end
endmodule

// File: rtl/frm_done_delay.sv
module frm_done_delay #(
  parameter int DATA_W   = 32,
  parameter int DH_LSB   = 4,
  parameter int DLY_LOAD = 7,
  parameter int DLY_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   eof,
  input  logic                   other_pend,
  input  logic                   dh_wr,
  input  logic [DATA_W-1:DH_LSB] dh_wdata,
  input  logic                   wdh_clr,
  input  logic                   dly_zero,
  output logic [DATA_W-1:0]      done_head,
  output logic [DATA_W-1:0]      done_capt,
  output logic                   wdh_irq,
  output logic [DLY_W-1:0]       dly_cnt
);
  localparam logic [DLY_W-1:0] LOAD_V = DLY_W'(DLY_LOAD);

  logic [DATA_W-1:DH_LSB] dh_q;
  logic [DLY_W-1:0]       dly_q;
  logic                   wdh_q;
  logic                   capture;

  assign capture = eof && (dly_q == '0) && !wdh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dh_q      <= '0;
      dly_q     <= '0;
      wdh_q     <= 1'b0;
      done_capt <= '0;
    end else begin
      // head: hand-back clears it and beats a write in the same cycle
      if (capture)    dh_q <= '0;
      else if (dh_wr) dh_q <= dh_wdata;

      if (capture) done_capt <= {dh_q, {(DH_LSB-1){1'b0}}, other_pend};

      if (capture)      wdh_q <= 1'b1;
      else if (wdh_clr) wdh_q <= 1'b0;

      if (dly_zero)     dly_q <= '0;
      else if (capture) dly_q <= LOAD_V;
      else if (eof && (dly_q != '0) && (dly_q != LOAD_V))
        dly_q <= dly_q - DLY_W'(1);
    end
  end

  assign done_head = {dh_q, {DH_LSB{1'b0}}};
  assign wdh_irq   = wdh_q;
  assign dly_cnt   = dly_q;
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import frm_pkg::*;
#(
  parameter int CNT_W     = FRM_CNT_W,
  parameter int FN_W      = FRM_NUM_W,
  parameter int DLY_LOAD  = FRM_DLY_LOAD,
  parameter int IVL_RESET = FRM_IVL_RESET,
  localparam int DLY_W    = $clog2(DLY_LOAD + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           run_en,
  input  logic                           bit_tick,
  input  logic                           ivl_wr,
  input  logic [CNT_W-1:0]               ivl_cnt_in,
  input  logic                           ivl_tgl_in,
  input  logic                           rem_lo_we,
  input  logic                           rem_hi_we,
  input  logic                           rem_tgl_we,
  input  logic [CNT_W-1:0]               rem_cnt_in,
  input  logic                           rem_tgl_in,
  input  logic                           dh_wr,
  input  logic [FRM_DATA_W-1:FRM_DH_LSB] dh_wdata,
  input  logic                           wdh_clr,
  input  logic                           dly_zero,
  input  logic                           irq_other_pend,
  output logic [FN_W-1:0]                frame_num,
  output logic [FRM_DATA_W-1:0]          remaining,
  output logic                           sof_pulse,
  output logic                           eof_pulse,
  output logic                           wdh_irq,
  output logic [FRM_DATA_W-1:0]          done_head,
  output logic [FRM_DATA_W-1:0]          done_capt,
  output logic [DLY_W-1:0]               dly_cnt
);
  localparam int PAD_W = FRM_TGL_BIT - CNT_W;

  logic             step, wrap, rem_tgl;
  logic [CNT_W-1:0] rem_cnt, ivl_cnt;

  assign step = run_en & bit_tick;

  frm_remaining #(.CNT_W(CNT_W), .IVL_RESET(IVL_RESET)) u_rem (
    .clk(clk), .rst(rst), .step(step),
    .ivl_wr(ivl_wr), .ivl_cnt_in(ivl_cnt_in), .ivl_tgl_in(ivl_tgl_in),
    .rem_lo_we(rem_lo_we), .rem_hi_we(rem_hi_we), .rem_tgl_we(rem_tgl_we),
    .rem_cnt_in(rem_cnt_in), .rem_tgl_in(rem_tgl_in),
    .cnt(rem_cnt), .tgl(rem_tgl), .ivl_cnt(ivl_cnt), .wrap(wrap)
  );

  frm_number #(.FN_W(FN_W)) u_num (
    .clk(clk), .rst(rst), .inc(wrap), .num(frame_num)
  );

  frm_done_delay #(
    .DATA_W(FRM_DATA_W), .DH_LSB(FRM_DH_LSB),
    .DLY_LOAD(DLY_LOAD), .DLY_W(DLY_W)
  ) u_dly (
    .clk(clk), .rst(rst), .eof(wrap), .other_pend(irq_other_pend),
    .dh_wr(dh_wr), .dh_wdata(dh_wdata), .wdh_clr(wdh_clr),
    .dly_zero(dly_zero), .done_head(done_head), .done_capt(done_capt),
    .wdh_irq(wdh_irq), .dly_cnt(dly_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eof_pulse <= 1'b0;
      sof_pulse <= 1'b0;
    end else begin
      eof_pulse <= wrap;
      sof_pulse <= eof_pulse;
    end
  end

  assign remaining = {rem_tgl, {PAD_W{1'b0}}, rem_cnt};
endmodule

// File: rtl/frm_checker.sv
module frm_checker #(
  parameter int CNT_W    = 14,
  parameter int FN_W     = 16,
  parameter int DLY_LOAD = 7,
  parameter int DLY_W    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             bit_tick,
  input logic             rem_lo_we,
  input logic             rem_hi_we,
  input logic             rem_tgl_we,
  input logic             dly_zero,
  input logic [CNT_W-1:0] rem_cnt,
  input logic [CNT_W-1:0] ivl_cnt,
  input logic [FN_W-1:0]  frame_num,
  input logic             eof_pulse,
  input logic             sof_pulse,
  input logic             wdh_irq,
  input logic [DLY_W-1:0] dly_cnt,
  input logic [31:0]      done_head
);
  logic rem_w, go;
  assign rem_w = rem_lo_we | rem_hi_we | rem_tgl_we;
  assign go    = run_en & bit_tick & !rem_w;

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (go && rem_cnt != '0) |=> rem_cnt == $past(rem_cnt) - CNT_W'(1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !rem_w) |=> ($stable(rem_cnt) && $stable(frame_num))); // R2
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (go && rem_cnt == '0) |=> (rem_cnt == $past(ivl_cnt) && frame_num == FN_W'($past(frame_num) + 1'b1))); // R3
  AST_SOF_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
    eof_pulse |=> sof_pulse); // R4
  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    rem_w |=> !eof_pulse); // R6
  AST_WDH_AT_EOF: assert property (@(posedge clk) disable iff (rst)
    $rose(wdh_irq) |-> (eof_pulse && done_head == 32'h0)); // R8
  AST_DLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dly_cnt == DLY_W'(DLY_LOAD) && !dly_zero) |=> dly_cnt == DLY_W'(DLY_LOAD)); // R10
endmodule

bind usb_frame_timer frm_checker #(
  .CNT_W(CNT_W), .FN_W(FN_W), .DLY_LOAD(DLY_LOAD), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .bit_tick(bit_tick),
  .rem_lo_we(rem_lo_we), .rem_hi_we(rem_hi_we), .rem_tgl_we(rem_tgl_we),
  .dly_zero(dly_zero), .rem_cnt(rem_cnt), .ivl_cnt(ivl_cnt),
  .frame_num(frame_num), .eof_pulse(eof_pulse), .sof_pulse(sof_pulse),
  .wdh_irq(wdh_irq), .dly_cnt(dly_cnt), .done_head(done_head)
);

// File: tb/usb_frame_timer_test.sv
`timescale 1ns/1ps
module usb_frame_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0, bit_tick = 1'b0;
  logic        ivl_wr = 1'b0, ivl_tgl_in = 1'b0;
  logic [13:0] ivl_cnt_in = '0;
  logic        rem_lo_we = 1'b0, rem_hi_we = 1'b0, rem_tgl_we = 1'b0, rem_tgl_in = 1'b0;
  logic [13:0] rem_cnt_in = '0;
  logic        dh_wr = 1'b0, wdh_clr = 1'b0, dly_zero = 1'b0, irq_other_pend = 1'b0;
  logic [31:4] dh_wdata = '0;
  logic [15:0] frame_num;
  logic [31:0] remaining, done_head, done_capt;
  logic        sof_pulse, eof_pulse, wdh_irq;
  logic [2:0]  dly_cnt;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  usb_frame_timer uut (
    .clk(clk), .rst(rst), .run_en(run_en), .bit_tick(bit_tick),
    .ivl_wr(ivl_wr), .ivl_cnt_in(ivl_cnt_in), .ivl_tgl_in(ivl_tgl_in),
    .rem_lo_we(rem_lo_we), .rem_hi_we(rem_hi_we), .rem_tgl_we(rem_tgl_we),
    .rem_cnt_in(rem_cnt_in), .rem_tgl_in(rem_tgl_in),
    .dh_wr(dh_wr), .dh_wdata(dh_wdata), .wdh_clr(wdh_clr),
    .dly_zero(dly_zero), .irq_other_pend(irq_other_pend),
    .frame_num(frame_num), .remaining(remaining), .sof_pulse(sof_pulse),
    .eof_pulse(eof_pulse), .wdh_irq(wdh_irq), .done_head(done_head),
    .done_capt(done_capt), .dly_cnt(dly_cnt)
  );

  // row: interval, start count, ticks, expected count, expected frames
  localparam int NV = 8;
  localparam logic [53:0] VEC [NV] = '{
    {14'd5,     14'd3,  8'd3,  14'd0,     4'd0},
    {14'd5,     14'd3,  8'd4,  14'd5,     4'd1},
    {14'd5,     14'd3,  8'd10, 14'd5,     4'd2},
    {14'd2,     14'd0,  8'd1,  14'd2,     4'd1},
    {14'd2,     14'd0,  8'd7,  14'd2,     4'd3},
    {14'd0,     14'd0,  8'd5,  14'd0,     4'd5},
    {14'd16383, 14'd2,  8'd3,  14'd16383, 4'd1},
    {14'd100,   14'd50, 8'd40, 14'd10,    4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
    end
  endtask

  task automatic wr_rem(input logic lo, input logic hi, input logic tg,
                        input logic [13:0] c, input logic t);
    rem_lo_we = lo; rem_hi_we = hi; rem_tgl_we = tg;
    rem_cnt_in = c; rem_tgl_in = t;
    cyc();
    rem_lo_we = 1'b0; rem_hi_we = 1'b0; rem_tgl_we = 1'b0;
  endtask

  task automatic wr_ivl(input logic [13:0] c, input logic t);
    ivl_wr = 1'b1; ivl_cnt_in = c; ivl_tgl_in = t;
    cyc();
    ivl_wr = 1'b0;
  endtask

  task automatic wr_dh(input logic [31:4] v);
    dh_wr = 1'b1; dh_wdata = v; cyc(); dh_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] f0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    cyc();
    // R1 reset state
    chk("R1 frame", {16'h0, frame_num}, 32'h0);
    chk("R1 remaining", remaining, 32'h0);
    chk("R1 wdh", {31'h0, wdh_irq}, 32'h0);
    chk("R1 dly", {29'h0, dly_cnt}, 32'h0);
    chk("R1 head", done_head, 32'h0);
    chk("R1 capt", done_capt, 32'h0);
    chk("R1 pulses", {30'h0, eof_pulse, sof_pulse}, 32'h0);
    // R2 ticks ignored while stopped
    ticks(3);
    chk("R2 stopped remaining", remaining, 32'h0);
    chk("R2 stopped frame", {16'h0, frame_num}, 32'h0);
    run_en = 1'b1;
    ticks(1);
    chk("R1 interval reset reload", remaining, 32'd11999);
    chk("R3 first frame", {16'h0, frame_num}, 32'h1);
    ticks(1);
    chk("R2 decrement", remaining, 32'd11998);

    // table of count / reload patterns (R3)
    for (int v = 0; v < NV; v++) begin
      wr_ivl(VEC[v][53:40], 1'b0);
      wr_rem(1'b1, 1'b1, 1'b0, VEC[v][39:26], 1'b0);
      f0 = frame_num;
      ticks(int'(VEC[v][25:18]));
      chk($sformatf("R3 row%0d count", v), remaining, {18'h0, VEC[v][17:4]});
      chk($sformatf("R3 row%0d frames", v), {16'h0, frame_num - f0}, {28'h0, VEC[v][3:0]});
    end

    // R5 write lanes
    wr_rem(1'b1, 1'b1, 1'b1, 14'h3FFF, 1'b1);
    chk("R5 all lanes", remaining, 32'h80003FFF);
    wr_rem(1'b0, 1'b1, 1'b0, 14'h0, 1'b0);
    chk("R5 high lane", remaining, 32'h800000FF);
    wr_rem(1'b0, 1'b0, 1'b1, 14'h0, 1'b0);
    chk("R5 toggle lane", remaining, 32'h000000FF);
    wr_rem(1'b1, 1'b0, 1'b0, 14'h1234, 1'b0);
    chk("R5 low lane", remaining, 32'h00000034);

    // R3 toggle copy
    wr_ivl(14'd3, 1'b1);
    wr_rem(1'b1, 1'b1, 1'b1, 14'h0, 1'b0);
    ticks(1);
    chk("R3 toggle set", remaining, 32'h80000003);
    wr_ivl(14'd2, 1'b0);
    ticks(4);
    chk("R3 toggle cleared", remaining, 32'h00000002);

    // R4 pulse timing
    wr_rem(1'b1, 1'b1, 1'b0, 14'h0, 1'b0);
    f0 = frame_num;
    ticks(1);
    chk("R4 eof", {30'h0, eof_pulse, sof_pulse}, 32'h2);
    chk("R3 frame inc", {16'h0, frame_num}, {16'h0, f0 + 16'd1});
    cyc();
    chk("R4 sof", {30'h0, eof_pulse, sof_pulse}, 32'h1);
    cyc();
    chk("R4 quiet", {30'h0, eof_pulse, sof_pulse}, 32'h0);

    // R6 write beats a zero tick in the same cycle
    wr_rem(1'b1, 1'b1, 1'b0, 14'h0, 1'b0);
    f0 = frame_num;
    bit_tick = 1'b1;
    wr_rem(1'b1, 1'b1, 1'b0, 14'd9, 1'b0);
    bit_tick = 1'b0;
    chk("R6 written value", remaining, 32'd9);
    chk("R6 no eof", {31'h0, eof_pulse}, 32'h0);
    chk("R6 frame held", {16'h0, frame_num}, {16'h0, f0});
    cyc();
    chk("R6 no sof", {31'h0, sof_pulse}, 32'h0);

    // R10/R11 force delay to zero and clear request
    wdh_clr = 1'b1; dly_zero = 1'b1; cyc(); wdh_clr = 1'b0; dly_zero = 1'b0;
    chk("R11 clear", {31'h0, wdh_irq}, 32'h0);
    chk("R10 forced zero", {29'h0, dly_cnt}, 32'h0);
    wr_dh(28'h0000ABC);
    chk("R7 head low bits", done_head, 32'h0000ABC0);
    // R8 hand-back
    wr_rem(1'b1, 1'b1, 1'b0, 14'h0, 1'b0);
    ticks(1);
    chk("R8 captured", done_capt, 32'h0000ABC0);
    chk("R8 head cleared", done_head, 32'h0);
    chk("R8 request", {31'h0, wdh_irq}, 32'h1);
    chk("R8 delay loaded", {29'h0, dly_cnt}, 32'd7);
    // R10 holds at 7
    wdh_clr = 1'b1; cyc(); wdh_clr = 1'b0;
    wr_dh(28'h0000010);
    wr_rem(1'b1, 1'b1, 1'b0, 14'h0, 1'b0);
    ticks(1);
    chk("R10 delay held", {29'h0, dly_cnt}, 32'd7);
    chk("R10 no request", {31'h0, wdh_irq}, 32'h0);
    chk("R10 head kept", done_head, 32'h00000100);
    chk("R10 capt kept", done_capt, 32'h0000ABC0);
    // R9 pending flag
    dly_zero = 1'b1; cyc(); dly_zero = 1'b0;
    irq_other_pend = 1'b1;
    wr_rem(1'b1, 1'b1, 1'b0, 14'h0, 1'b0);
    ticks(1);
    chk("R9 capt bit0", done_capt, 32'h00000101);
    chk("R9 delay", {29'h0, dly_cnt}, 32'd7);
    // R8 request blocks capture
    dly_zero = 1'b1; cyc(); dly_zero = 1'b0;
    wr_dh(28'h0000020);
    wr_rem(1'b1, 1'b1, 1'b0, 14'h0, 1'b0);
    ticks(1);
    chk("R8 blocked delay", {29'h0, dly_cnt}, 32'd0);
    chk("R8 blocked head", done_head, 32'h00000200);
    chk("R8 blocked capt", done_capt, 32'h00000101);
    // R11 capture beats clear
    wdh_clr = 1'b1; cyc(); wdh_clr = 1'b0;
    wr_rem(1'b1, 1'b1, 1'b0, 14'h0, 1'b0);
    wdh_clr = 1'b1; ticks(1); wdh_clr = 1'b0;
    chk("R11 capture wins", {31'h0, wdh_irq}, 32'h1);
    chk("R11 capt", done_capt, 32'h00000201);
    irq_other_pend = 1'b0;

    // R12 frame number wrap
    wr_ivl(14'd0, 1'b0);
    wr_rem(1'b1, 1'b1, 1'b0, 14'h0, 1'b0);
    f0 = frame_num;
    if (f0 != 16'hFFFF) begin
      bit_tick = 1'b1;
      repeat (int'(16'hFFFF - f0)) @(posedge clk);
      #1 bit_tick = 1'b0;
    end
    chk("R12 top", {16'h0, frame_num}, 32'h0000FFFF);
    ticks(1);
    chk("R12 wrap", {16'h0, frame_num}, 32'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule